// File: doc/BRIEF.md
# Sector Reed-Solomon Parity Engine

This block sits beside a NAND flash byte stream and computes a Reed-Solomon check code over each 512-byte sector as the bytes go past. It works over GF(2^10), built from the primitive polynomial x^10 + x^3 + 1 (0x409). The generator has six roots, alpha^0 through alpha^5, so each codeword carries six 10-bit parity symbols. Every incoming byte is inverted and then zero-extended to a 10-bit symbol before it enters the division. As a result, an erased sector whose bytes are all 0xFF yields an all-0xFF code in the inverted readout bank.

Software controls the engine over a 16-bit register bus. On a program operation, software clears the engine in generate mode, streams the sector, and reads the eight code bytes from the inverted bank to store them in the spare area. On a read operation, software clears the engine in check mode and streams the sector followed by the eight stored bytes. It then reads a single flag that shows whether the remainder is non-zero. Only when the flag is set does software fetch the remainder from the banks for its own correction routine.

Top module: `rs_parity_engine`

## Requirements
- R1: After reset, the control and check registers read 0. Every inverted-bank byte reads 0xFF. True-bank bytes 0 to 6 read 0x00 and true-bank byte 7 reads 0x0F.
- R2: In generate mode, the parity is the remainder of M(x)*x^6 divided by g(x) = (x+alpha^0)...(x+alpha^5) over GF(2^10) with polynomial 0x409. M(x) has the sector's inverted bytes as 10-bit coefficients, and the first byte is the highest power. Appending the parity symbols, highest power first, gives a word whose syndromes at alpha^0..alpha^5 are all zero.
- R3: A generated sector of all 0xFF bytes reads 0xFF from all eight inverted-bank bytes.
- R4: Parity symbol k (k=0 is the x^5 coefficient) occupies bits 10k..10k+9 of a 64-bit packed word. Byte j of that word holds bits 8j..8j+7. Bits 60..63 are unused and read as 1.
- R5: Address 16+j returns the inverted packed byte j, with the unused bits still reading 1. Address 8+j returns packed byte j with its bit order reversed, for j = 0..7.
- R6: A write to address 0 sets the generate mode from bit 6 and the feed enable from bit 5. Bit 7 = 1 additionally clears the parity, the flag and the byte count, even in mid-sector. A read of address 0 returns bits 6 and 5, with bit 7 reading 0.
- R7: While the feed enable is 0, byte strobes change nothing. Feeding can resume without a clear, and the result equals that of an uninterrupted sector.
- R8: In generate mode the parity freezes after the 512th byte, and later strobes are ignored until the next clear.
- R9: In check mode, the 8 stored bytes follow the data. They are read as inverted packed bytes, and their unused bits 60..63 are ignored. In the cycle after the last stored byte, the banks show the remainder (computed parity XOR stored parity), and bit 7 of the check register (address 1) reads 1 exactly when that remainder is non-zero. Before that cycle, the flag reads 0.
- R10: Writing 0x00 to address 0 stops feeding, and it keeps both the remainder and the flag readable.
- R11: Bits 15..8 of read data are always 0. Addresses not listed above read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register word address (read and write) |
| bus_wdata | input | 8 | Write data (the writable bits of the 16-bit bus) |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| dat_stb | input | 1 | One sector or stored-code byte is valid this cycle |
| dat_byte | input | 8 | Byte on the flash data path |

## Verification
A wrong divider coefficient or a wrong symbol order only becomes visible after an entire sector has been processed. It then appears as a non-zero syndrome of the read-back codeword, so the bench judges each sector by evaluating syndromes, not by comparing against a copy of the encoder. A wrong byte count or a bad freeze shows up one cycle after the 512th byte or the 8th stored byte: the banks still change, or the flag does not rise exactly then. Corrupted single bits in the data and in the stored bytes must raise the flag. The remainder they leave must turn the received word back into a codeword.

// File: rtl/rsp_pkg.sv
package rsp_pkg;

    localparam int SYM_W  = 10;
    localparam logic [SYM_W:0] FIELD_POLY = 11'h409;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = 16;
    localparam int ADDR_W = 5;

    // register word addresses
    localparam logic [ADDR_W-1:0] A_CTRL  = 5'd0;
    localparam logic [ADDR_W-1:0] A_CHECK = 5'd1;
    localparam logic [ADDR_W-1:0] A_TRUE  = 5'd8;
    localparam logic [ADDR_W-1:0] A_INV   = 5'd16;

    // control and check bit positions
    localparam int CLR_BIT  = 7;
    localparam int GEN_BIT  = 6;
    localparam int FEED_BIT = 5;
    localparam int ERR_BIT  = 7;

    typedef enum logic [1:0] {
        PH_DATA = 2'd0,
        PH_CODE = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic logic [SYM_W-1:0] gf_xtime(input logic [SYM_W-1:0] a);
        logic [SYM_W-1:0] s;
        s = {a[SYM_W-2:0], 1'b0};
        if (a[SYM_W-1]) s = s ^ FIELD_POLY[SYM_W-1:0];
        return s;
    endfunction

    function automatic logic [SYM_W-1:0] gf_mul(input logic [SYM_W-1:0] a,
                                                input logic [SYM_W-1:0] b);
        logic [SYM_W-1:0] p;
        p = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            p = gf_xtime(p);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    function automatic logic [SYM_W-1:0] gf_alpha_pow(input int e);
        logic [SYM_W-1:0] p;
        p = SYM_W'(1);
        for (int i = 0; i < e; i++) p = gf_xtime(p);
        return p;
    endfunction

endpackage

// File: rtl/rsp_lfsr.sv
module rsp_lfsr
    import rsp_pkg::*;
#(
    parameter int NPAR = 6,
    parameter int FCR  = 0,
    localparam int PAR_W = NPAR * SYM_W
) (
    input  logic [PAR_W-1:0] par_i,
    input  logic [SYM_W-1:0] sym_i,
    output logic [PAR_W-1:0] par_o
);

    // generator coefficients g[0..NPAR], g[NPAR] == 1
    function automatic logic [(NPAR+1)*SYM_W-1:0] gen_coeffs();
        logic [(NPAR+1)*SYM_W-1:0] g;
        logic [SYM_W-1:0] root;
        g = '0;
        g[SYM_W-1:0] = SYM_W'(1);
        root = gf_alpha_pow(FCR);
        for (int i = 0; i < NPAR; i++) begin
            for (int k = NPAR; k >= 1; k--) begin
                g[k*SYM_W +: SYM_W] = g[(k-1)*SYM_W +: SYM_W]
                                    ^ gf_mul(g[k*SYM_W +: SYM_W], root);
            end
            g[0 +: SYM_W] = gf_mul(g[0 +: SYM_W], root);
            root = gf_xtime(root);
        end
        return g;
    endfunction

    localparam logic [(NPAR+1)*SYM_W-1:0] GEN = gen_coeffs();

    logic [SYM_W-1:0] fb;
    assign fb = sym_i ^ par_i[(NPAR-1)*SYM_W +: SYM_W];

    for (genvar k = 0; k < NPAR; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign par_o[0 +: SYM_W] = gf_mul(fb, GEN[0 +: SYM_W]);
        end else begin : g_rest
            assign par_o[k*SYM_W +: SYM_W] = par_i[(k-1)*SYM_W +: SYM_W]
                                           ^ gf_mul(fb, GEN[k*SYM_W +: SYM_W]);
        end
    end

endmodule

// File: rtl/rsp_pack.sv
module rsp_pack
    import rsp_pkg::*;
#(
    parameter int NPAR = 6,
    localparam int PAR_W      = NPAR * SYM_W,
    localparam int CODE_BYTES = (PAR_W + BYTE_W - 1) / BYTE_W,
    localparam int CODE_W     = CODE_BYTES * BYTE_W
) (
    input  logic [PAR_W-1:0]  par_i,
    output logic [CODE_W-1:0] code_o
);

    // highest-power symbol lands in the lowest bits
    for (genvar k = 0; k < NPAR; k++) begin : g_sym
        assign code_o[k*SYM_W +: SYM_W] = par_i[(NPAR-1-k)*SYM_W +: SYM_W];
    end

    if (CODE_W > PAR_W) begin : g_fill
        assign code_o[CODE_W-1:PAR_W] = '1;
    end

endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
    import rsp_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int NPAR         = 6,
    parameter int FCR          = 0,
    localparam int PAR_W      = NPAR * SYM_W,
    localparam int CODE_BYTES = (PAR_W + BYTE_W - 1) / BYTE_W,
    localparam int CNT_MAX    = (SECTOR_BYTES > CODE_BYTES) ? SECTOR_BYTES : CODE_BYTES,
    localparam int CNT_W      = (CNT_MAX > 1) ? $clog2(CNT_MAX) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_wdata,
    input  logic              dat_stb,
    input  logic [BYTE_W-1:0] dat_byte,
    output logic [PAR_W-1:0]  par_o,
    output logic              err_o,
    output logic              gen_o,
    output logic              feed_o,
    output phase_e            phase_o
);

    typedef struct packed {
        phase_e           phase;
        logic             gen;
        logic             feed;
        logic             err;
        logic [CNT_W-1:0] cnt;
        logic [PAR_W-1:0] par;
        logic [PAR_W-1:0] code;
    } seq_t;

    seq_t st_d, st_q;

    logic [SYM_W-1:0] sym_in;
    logic [PAR_W-1:0] par_step;
    logic [PAR_W-1:0] stored;
    logic [PAR_W-1:0] rem;
    logic             clr;
    logic             take;

    assign sym_in = {{(SYM_W-BYTE_W){1'b0}}, ~dat_byte};

    rsp_lfsr #(.NPAR(NPAR), .FCR(FCR)) u_lfsr (
        .par_i (st_q.par),
        .sym_i (sym_in),
        .par_o (par_step)
    );

    always_comb begin
        st_d   = st_q;
        stored = '0;
        rem    = '0;
        clr    = ctl_wr && ctl_wdata[CLR_BIT];
        take   = dat_stb && st_q.feed && (st_q.phase != PH_DONE) && !clr;

        if (ctl_wr) begin
            st_d.gen  = ctl_wdata[GEN_BIT];
            st_d.feed = ctl_wdata[FEED_BIT];
            if (clr) begin
                st_d.phase = PH_DATA;
                st_d.err   = 1'b0;
                st_d.cnt   = '0;
                st_d.par   = '0;
                st_d.code  = '0;
            end
        end

        if (take) begin
            unique case (st_q.phase)
                PH_DATA: begin
                    st_d.par = par_step;
                    if (st_q.cnt == CNT_W'(SECTOR_BYTES - 1)) begin
                        st_d.cnt   = '0;
                        st_d.phase = st_q.gen ? PH_DONE : PH_CODE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_CODE: begin
                    // stored bytes arrive inverted; bits past the parity are dropped
                    for (int j = 0; j < CODE_BYTES; j++) begin
                        if (st_q.cnt == CNT_W'(j)) begin
                            for (int b = 0; b < BYTE_W; b++) begin
                                if (j * BYTE_W + b < PAR_W)
                                    st_d.code[j*BYTE_W + b] = ~dat_byte[b];
                            end
                        end
                    end
                    if (st_q.cnt == CNT_W'(CODE_BYTES - 1)) begin
                        for (int k = 0; k < NPAR; k++)
                            stored[(NPAR-1-k)*SYM_W +: SYM_W] = st_d.code[k*SYM_W +: SYM_W];
                        rem        = st_q.par ^ stored;
                        st_d.par   = rem;
                        st_d.err   = |rem;
                        st_d.cnt   = '0;
                        st_d.phase = PH_DONE;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_DATA, gen: 1'b0, feed: 1'b0, err: 1'b0,
                      cnt: '0, par: '0, code: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign par_o   = st_q.par;
    assign err_o   = st_q.err;
    assign gen_o   = st_q.gen;
    assign feed_o  = st_q.feed;
    assign phase_o = st_q.phase;

endmodule

// File: rtl/rsp_rdmux.sv
module rsp_rdmux
    import rsp_pkg::*;
#(
    parameter int CODE_BYTES = 8,
    localparam int CODE_W = CODE_BYTES * BYTE_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              gen_i,
    input  logic              feed_i,
    input  logic              err_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [BUS_W-1:0]  rdata_o
);

    logic [BYTE_W-1:0] lo;

    always_comb begin
        lo = '0;
        if (addr_i == A_CTRL) begin
            lo[GEN_BIT]  = gen_i;
            lo[FEED_BIT] = feed_i;
        end
        if (addr_i == A_CHECK) lo[ERR_BIT] = err_i;
        for (int j = 0; j < CODE_BYTES; j++) begin
            if (addr_i == A_TRUE + ADDR_W'(j)) begin
                for (int b = 0; b < BYTE_W; b++)
                    lo[b] = code_i[j*BYTE_W + BYTE_W - 1 - b];
            end
            if (addr_i == A_INV + ADDR_W'(j)) begin
                lo = ~code_i[j*BYTE_W +: BYTE_W];
                // padding above the parity keeps reading as ones
                for (int b = 0; b < BYTE_W; b++)
                    if (j * BYTE_W + b >= CODE_W - (CODE_W % SYM_W) && (CODE_W % SYM_W) != 0)
                        lo[b] = 1'b1;
            end
        end
        rdata_o = {{(BUS_W-BYTE_W){1'b0}}, lo};
    end

endmodule

// File: rtl/rs_parity_engine.sv
module rs_parity_engine
    import rsp_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int NPAR         = 6,
    parameter int FCR          = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [4:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              dat_stb,
    input  logic [7:0]        dat_byte
);

    localparam int PAR_W      = NPAR * SYM_W;
    localparam int CODE_BYTES = (PAR_W + BYTE_W - 1) / BYTE_W;
    localparam int CODE_W     = CODE_BYTES * BYTE_W;

    logic              ctl_wr;
    logic [PAR_W-1:0]  par_w;
    logic [CODE_W-1:0] code_w;
    logic              err_w;
    logic              gen_w;
    logic              feed_w;
    phase_e            phase_w;

    assign ctl_wr = bus_wr && (bus_addr == A_CTRL);

    rsp_seq #(.SECTOR_BYTES(SECTOR_BYTES), .NPAR(NPAR), .FCR(FCR)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (bus_wdata),
        .dat_stb   (dat_stb),
        .dat_byte  (dat_byte),
        .par_o     (par_w),
        .err_o     (err_w),
        .gen_o     (gen_w),
        .feed_o    (feed_w),
        .phase_o   (phase_w)
    );

    rsp_pack #(.NPAR(NPAR)) u_pack (
        .par_i  (par_w),
        .code_o (code_w)
    );

    rsp_rdmux #(.CODE_BYTES(CODE_BYTES)) u_rdmux (
        .addr_i  (bus_addr),
        .gen_i   (gen_w),
        .feed_i  (feed_w),
        .err_i   (err_w),
        .code_i  (code_w),
        .rdata_o (bus_rdata)
    );

endmodule

// File: rtl/rsp_chk.sv
module rsp_chk
    import rsp_pkg::*;
#(
    parameter int PAR_W = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             clr_bit,
    input logic             feed,
    input logic             err,
    input phase_e           phase,
    input logic [PAR_W-1:0] par,
    input logic [BUS_W-1:0] rdata
);

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr && clr_bit |=> (par == '0) && !err && (phase == PH_DATA));

    // R8
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE) && !(ctl_wr && clr_bit) |=> $stable(par) && $stable(err));

    // R7
    nofeed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !feed && !ctl_wr |=> $stable(par) && $stable(phase));

    // R9
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> ($past(phase) == PH_CODE) && (phase == PH_DONE));

    // R11
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[BUS_W-1:BYTE_W] == '0);

endmodule

bind rs_parity_engine rsp_chk #(.PAR_W(NPAR * rsp_pkg::SYM_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .clr_bit (bus_wdata[7]),
    .feed    (feed_w),
    .err     (err_w),
    .phase   (phase_w),
    .par     (par_w),
    .rdata   (bus_rdata)
);

// File: tb/rs_parity_engine_bench.sv
module rs_parity_engine_bench;

    localparam int NB = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'd0;
    logic [7:0]  bus_wdata = 8'd0;
    logic [15:0] bus_rdata;
    logic        dat_stb = 1'b0;
    logic [7:0]  dat_byte = 8'd0;

    int n_chk = 0;
    int n_err = 0;

    logic [7:0] dbuf [NB];
    logic [7:0] tru [8];
    logic [7:0] inv [8];
    logic [7:0] refb [8];
    logic [7:0] stb [8];
    logic [31:0] lcg = 32'h1234_5678;

    rs_parity_engine u_rs_parity_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dat_stb(dat_stb), .dat_byte(dat_byte)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // ---------- field arithmetic for syndrome evaluation ----------
    function automatic logic [9:0] gx(input logic [9:0] a);
        return a[9] ? ({a[8:0], 1'b0} ^ 10'h009) : {a[8:0], 1'b0};
    endfunction

    function automatic logic [9:0] gmul(input logic [9:0] a, input logic [9:0] b);
        logic [9:0] p = 10'd0;
        logic [9:0] t = a;
        for (int i = 0; i < 10; i++) begin
            if (b[i]) p = p ^ t;
            t = gx(t);
        end
        return p;
    endfunction

    function automatic bit syn_zero(input logic [59:0] pk);
        logic [9:0] a = 10'd1;
        for (int i = 0; i < 6; i++) begin
            logic [9:0] s = 10'd0;
            for (int n = 0; n < NB; n++) s = gmul(s, a) ^ {2'b00, ~dbuf[n]};
            for (int k = 0; k < 6; k++) s = gmul(s, a) ^ pk[10*k +: 10];
            if (s != 10'd0) return 1'b0;
            a = gx(a);
        end
        return 1'b1;
    endfunction

    function automatic logic [7:0] brev(input logic [7:0] v);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) r[b] = v[7-b];
        return r;
    endfunction

    function automatic logic [7:0] nextr();
        lcg = lcg * 32'd1103515245 + 32'd12345;
        return lcg[23:16];
    endfunction

    // ---------- bus and stream tasks ----------
    task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        bus_addr = a;
        #2 v = bus_rdata;
    endtask

    task automatic feed_data(input int lo, input int hi);
        for (int i = lo; i < hi; i++) begin
            @(negedge clk);
            dat_stb = 1'b1; dat_byte = dbuf[i];
        end
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic feed_junk(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dat_stb = 1'b1; dat_byte = nextr();
        end
        @(negedge clk);
        dat_stb = 1'b0;
    endtask

    task automatic fill(input int kind);
        logic [31:0] x = 32'hCAFE_0001;
        for (int i = 0; i < NB; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            case (kind)
                0: dbuf[i] = 8'hFF;
                1: dbuf[i] = 8'h00;
                2: dbuf[i] = 8'(i) ^ 8'(i >> 8);
                default: dbuf[i] = x[23:16];
            endcase
        end
    endtask

    task automatic read_banks();
        logic [15:0] v;
        for (int j = 0; j < 8; j++) begin
            bus_read(5'(8 + j), v);  tru[j] = v[7:0];
            bus_read(5'(16 + j), v); inv[j] = v[7:0];
        end
    endtask

    function automatic logic [63:0] inv64();
        logic [63:0] r;
        for (int j = 0; j < 8; j++) r[8*j +: 8] = inv[j];
        return r;
    endfunction

    // R4 / R5 layout consistency between the two banks
    task automatic layout();
        bit ok = 1'b1;
        for (int j = 0; j < 7; j++) if (tru[j] != brev(~inv[j])) ok = 1'b0;
        if (tru[7] != brev({4'hF, ~inv[7][3:0]})) ok = 1'b0;
        chk(ok, "R5 true bank is bit-reversed packed byte", {tru[7], tru[6], tru[5], tru[4], tru[3], tru[2], tru[1], tru[0]}, ~inv64());
        chk(inv[7][7:4] == 4'hF, "R4 unused bits 60..63 read 1", 64'(inv[7]), 64'hF0);
    endtask

    task automatic write_sector();
        bus_write(5'd0, 8'hE0);
        feed_data(0, NB);
    endtask

    task automatic read_sector(input bit exp_err);
        bus_write(5'd0, 8'hA0);
        feed_data(0, NB);
        for (int j = 0; j < 8; j++) begin
            @(negedge clk);
            bus_addr = 5'd1; dat_stb = 1'b1; dat_byte = stb[j];
            if (j == 7) begin
                #2 chk(bus_rdata == 16'h0000, "R9 flag low before last stored byte", 64'(bus_rdata), 64'h0);
            end
        end
        @(negedge clk);
        dat_stb = 1'b0;
        #2 chk(bus_rdata == {8'h00, exp_err, 7'b0}, "R9 flag in cycle after last stored byte",
               64'(bus_rdata), 64'({exp_err, 7'b0}));
    endtask

    initial begin
        logic [15:0] v;
        logic [59:0] recv, rem;
        bit ok;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'd0, v); chk(v == 16'h0, "R1 ctrl after reset", 64'(v), 64'h0);
        bus_read(5'd1, v); chk(v == 16'h0, "R1 check after reset", 64'(v), 64'h0);
        bus_read(5'd2, v); chk(v == 16'h0, "R11 unmapped address 2", 64'(v), 64'h0);
        bus_read(5'd31, v); chk(v == 16'h0, "R11 unmapped address 31", 64'(v), 64'h0);
        read_banks();
        chk(inv64() == 64'hFFFF_FFFF_FFFF_FFFF, "R1 inverted bank after reset", inv64(), 64'hFFFF_FFFF_FFFF_FFFF);
        ok = 1'b1;
        for (int j = 0; j < 7; j++) if (tru[j] != 8'h00) ok = 1'b0;
        chk(ok && tru[7] == 8'h0F, "R1 true bank after reset", 64'(tru[7]), 64'h0F);

        // R3 erased sector
        fill(0); write_sector(); read_banks(); layout();
        chk(inv64() == 64'hFFFF_FFFF_FFFF_FFFF, "R3 erased sector code", inv64(), 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(5'd0, v); chk(v == 16'h0060, "R6 ctrl readback after 0xE0", 64'(v), 64'h60);

        // R2 several patterns
        for (int p = 1; p < 4; p++) begin
            fill(p); write_sector(); read_banks(); layout();
            recv = ~inv64()[59:0];
            chk(syn_zero(recv), "R2 codeword syndromes zero", 64'(recv), 64'h0);
        end
        for (int j = 0; j < 8; j++) refb[j] = inv[j];

        // R8 strobes after the sector are ignored
        feed_junk(20); read_banks();
        ok = 1'b1; for (int j = 0; j < 8; j++) if (inv[j] != refb[j]) ok = 1'b0;
        chk(ok, "R8 parity frozen after 512 bytes", inv64(), 64'(refb[0]));

        // R7 pause feeding, then resume without clear
        bus_write(5'd0, 8'hE0);
        feed_data(0, 100);
        bus_write(5'd0, 8'h40);
        bus_read(5'd0, v); chk(v == 16'h0040, "R6 ctrl readback 0x40", 64'(v), 64'h40);
        feed_junk(30);
        bus_write(5'd0, 8'h60);
        feed_data(100, NB);
        read_banks();
        ok = 1'b1; for (int j = 0; j < 8; j++) if (inv[j] != refb[j]) ok = 1'b0;
        chk(ok, "R7 paused sector matches uninterrupted", inv64(), 64'(refb[0]));

        // R6 clear in mid-sector
        bus_write(5'd0, 8'hE0);
        feed_junk(50);
        write_sector(); read_banks();
        ok = 1'b1; for (int j = 0; j < 8; j++) if (inv[j] != refb[j]) ok = 1'b0;
        chk(ok, "R6 clear restarts the sector", inv64(), 64'(refb[0]));

        // R9 clean read
        for (int j = 0; j < 8; j++) stb[j] = refb[j];
        read_sector(1'b0); read_banks();
        chk(inv64() == 64'hFFFF_FFFF_FFFF_FFFF, "R9 zero remainder on clean read", inv64(), 64'hFFFF_FFFF_FFFF_FFFF);

        // R9 unused stored bits ignored
        stb[7] = {4'h0, refb[7][3:0]};
        read_sector(1'b0);

        // R9 / R10 single-bit error sweep over data and stored bytes
        for (int e = 0; e < 16; e++) begin
            fill(3);
            for (int j = 0; j < 8; j++) stb[j] = refb[j];
            if (e < 12) begin
                int pos;
                case (e % 4) 0: pos = 0; 1: pos = 1; 2: pos = 255; default: pos = 511; endcase
                dbuf[pos] = dbuf[pos] ^ (8'h01 << (e / 4) * 3);
            end else begin
                int cb;
                cb = (e == 12) ? 0 : (e == 13) ? 3 : (e == 14) ? 5 : 7;
                stb[cb] = stb[cb] ^ 8'h04;
            end
            read_sector(1'b1);
            bus_write(5'd0, 8'h00);
            bus_read(5'd0, v); chk(v == 16'h0, "R10 ctrl reads 0 after 0x00", 64'(v), 64'h0);
            bus_read(5'd1, v); chk(v == 16'h0080, "R10 flag kept after 0x00", 64'(v), 64'h80);
            read_banks(); layout();
            rem = ~inv64()[59:0];
            for (int j = 0; j < 8; j++) recv[8*j +: 8] = (j < 7) ? ~stb[j] : 8'(recv[59:56]);
            recv[59:56] = ~stb[7][3:0];
            chk(rem != 60'd0, "R9 remainder non-zero", 64'(rem), 64'h1);
            chk(syn_zero(recv ^ rem), "R9 remainder restores a codeword", 64'(rem), 64'h0);
        end

        summary();
        $finish;
    end

endmodule